// File: doc/BRIEF.md
# Board Control Register File

This block is the memory-mapped control and status register file of an evaluation board. A bus master performs single-cycle 32-bit reads and writes. Only the low 20 bits of the address take part in decoding, so the register window repeats throughout the wider address space. The block drives the board's outputs: an eight-LED bar, an eight-character ASCII display exposed as one 64-bit vector, a general-purpose output byte, bit-banged I2C clock and data lines with their enables, and a one-cycle soft-reset request. It also reports the live I2C data input and fixed identification values.

The display can be loaded in two ways. A single word write turns a 32-bit value into eight uppercase hexadecimal characters. Alternatively, eight per-character byte registers each place one character. The soft-reset request is guarded by a key value. A small two-state machine registers the request, with states IDLE and FIRE. The machine goes from IDLE to FIRE on a keyed write, stays in FIRE while keyed writes keep arriving, and returns from FIRE to IDLE on any other cycle. Read data is registered: it appears one cycle after the read strobe, together with a valid flag.

Top module: `brd_ctl_regs`

## Requirements
- R1: Decoding uses only address bits 19:0, so any value in bits 31:20 reaches the same register. Offsets that are not mapped read as zero, and writes to them change no output and no readable register.
- R2: Offset 0x200 and offset 0x210 read as zero, and writes to them are ignored. The status word at offset 0x208 reads 0x12 when the big-endian parameter is set and 0x10 otherwise.
- R3: The LED register at offset 0x408 keeps bits 7:0 of a write, drives them on `led_o`, and reads them back zero-extended.
- R4: A write to offset 0x410 loads all eight characters. Character i comes from data nibble 7−i, encoded as ASCII '0'–'9' or 'A'–'F'. Character i appears on `disp_o[8*i+7:8*i]`.
- R5: A write to offset 0x418 + 8·i, for i from 0 to 7, stores data bits 7:0 as character i and leaves the other characters unchanged. The display changes only on these writes and on the word write.
- R6: A write of exactly 0x42 to offset 0x500 raises `soft_rst_o` for exactly the one cycle after the write edge. Any other value written there leaves `soft_rst_o` low.
- R7: The break register at offset 0x508 keeps 8 bits and resets to 0x0A. The general-purpose output at offset 0xA00 keeps 8 bits, drives `gpo_o`, and resets to 0.
- R8: The I2C output word at offset 0xB10 keeps all 32 bits and resets to 0x3. Its bit 1 drives `i2c_scl_o` and its bit 0 drives `i2c_sda_o`. Offset 0xB08 is a 2-bit enable register that drives `i2c_oe_o` and resets to 0. Offset 0xB18 is a 1-bit select register that resets to 1.
- R9: Offset 0xB00 reads 0x2 OR the live `i2c_sda_i` in bit 0. Offset 0xA08 reads the I2C output word while select is 1, and reads zero while select is 0.
- R10: After reset the display holds eight ASCII spaces (0x20), the LED register is 0, and `soft_rst_o` is low.
- R11: A read strobe sampled at a clock edge produces `bus_rvalid` and the addressed value on `bus_rdata` during the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 32 | Byte address; bits 19:0 are decoded |
| bus_wdata | input | 32 | Write data |
| bus_wr_en | input | 1 | Write strobe, one access per cycle |
| bus_rd_en | input | 1 | Read strobe, one access per cycle |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the strobe |
| i2c_sda_i | input | 1 | Live I2C data input |
| led_o | output | 8 | LED bar |
| disp_o | output | 64 | Display characters, character i in byte i |
| gpo_o | output | 8 | General-purpose output byte |
| i2c_scl_o | output | 1 | I2C clock line value |
| i2c_sda_o | output | 1 | I2C data line value |
| i2c_oe_o | output | 2 | I2C line output enables |
| soft_rst_o | output | 1 | One-cycle soft-reset request |

## Verification
The in-line assertions run on every cycle. They check that the LED, general-purpose and display outputs hold still when no write targets them. They check that a soft-reset pulse is always preceded by a keyed write, and that read-valid follows each read strobe. The bench's scenarios are needed for the remaining behaviour. These are the exact values produced by hex conversion and per-character placement, the rejection of keys other than 0x42, address aliasing through the upper bits, and the select-dependent loopback. The bench also covers the reset values of every register.

// File: rtl/brd_ctl_pkg.sv
package brd_ctl_pkg;

    localparam int DEC_W = 20;

    typedef enum logic [0:0] {
        SR_IDLE = 1'b0,
        SR_FIRE = 1'b1
    } srst_state_e;

    localparam logic [DEC_W-1:0] OFS_SWITCH  = 20'h00200;
    localparam logic [DEC_W-1:0] OFS_STATUS  = 20'h00208;
    localparam logic [DEC_W-1:0] OFS_JUMPER  = 20'h00210;
    localparam logic [DEC_W-1:0] OFS_LEDS    = 20'h00408;
    localparam logic [DEC_W-1:0] OFS_HEXWORD = 20'h00410;
    localparam logic [DEC_W-1:0] OFS_CHAR0   = 20'h00418;
    localparam logic [DEC_W-1:0] OFS_SRST    = 20'h00500;
    localparam logic [DEC_W-1:0] OFS_BRK     = 20'h00508;
    localparam logic [DEC_W-1:0] OFS_GPO     = 20'h00A00;
    localparam logic [DEC_W-1:0] OFS_LOOP    = 20'h00A08;
    localparam logic [DEC_W-1:0] OFS_I2C_IN  = 20'h00B00;
    localparam logic [DEC_W-1:0] OFS_I2C_OE  = 20'h00B08;
    localparam logic [DEC_W-1:0] OFS_I2C_OUT = 20'h00B10;
    localparam logic [DEC_W-1:0] OFS_I2C_SEL = 20'h00B18;

    function automatic logic [7:0] nib2ascii(input logic [3:0] n);
        return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
    endfunction

endpackage

// File: rtl/brd_hex_enc.sv
module brd_hex_enc #(
    parameter int NCHARS = 8
) (
    input  logic [4*NCHARS-1:0] word_i,
    output logic [8*NCHARS-1:0] chars_o
);
    import brd_ctl_pkg::*;

    for (genvar i = 0; i < NCHARS; i++) begin : g_nib
        // character 0 takes the most significant nibble
        assign chars_o[8*i +: 8] = nib2ascii(word_i[4*(NCHARS-1-i) +: 4]);
    end

endmodule

// File: rtl/brd_disp_buf.sv
module brd_disp_buf #(
    parameter int NCHARS = 8,
    localparam int IDX_W = $clog2(NCHARS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_word_i,
    input  logic                wr_char_i,
    input  logic [IDX_W-1:0]    char_idx_i,
    input  logic [4*NCHARS-1:0] word_i,
    input  logic [7:0]          char_i,
    output logic [8*NCHARS-1:0] disp_o
);
    logic [8*NCHARS-1:0] hex_chars;

    brd_hex_enc #(.NCHARS(NCHARS)) u_hex (
        .word_i (word_i),
        .chars_o(hex_chars)
    );

    for (genvar i = 0; i < NCHARS; i++) begin : g_char
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                disp_o[8*i +: 8] <= 8'h20;
            end else if (wr_word_i) begin
                disp_o[8*i +: 8] <= hex_chars[8*i +: 8];
            end else if (wr_char_i && (char_idx_i == IDX_W'(i))) begin
                disp_o[8*i +: 8] <= char_i;
            end
        end
    end

    AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_word_i || wr_char_i) |=> $stable(disp_o)); // R5

endmodule

// File: rtl/brd_srst_fsm.sv
module brd_srst_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic key_hit_i,
    output logic pulse_o
);
    import brd_ctl_pkg::*;

    srst_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SR_IDLE: state_d = key_hit_i ? SR_FIRE : SR_IDLE;
            SR_FIRE: state_d = key_hit_i ? SR_FIRE : SR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pulse_o = (state_q == SR_FIRE);
    end

    AST_SRST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> $past(key_hit_i)); // R6

endmodule

// File: rtl/brd_ctl_regs.sv
module brd_ctl_regs #(
    parameter int          ADDR_W     = 32,
    parameter int          DATA_W     = 32,
    parameter int          NCHARS     = 8,
    parameter bit          BIG_ENDIAN = 1'b0,
    parameter logic [7:0]  SRST_KEY   = 8'h42,
    localparam int         IDX_W      = $clog2(NCHARS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_wr_en,
    input  logic                bus_rd_en,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_rvalid,
    input  logic                i2c_sda_i,
    output logic [7:0]          led_o,
    output logic [8*NCHARS-1:0] disp_o,
    output logic [7:0]          gpo_o,
    output logic                i2c_scl_o,
    output logic                i2c_sda_o,
    output logic [1:0]          i2c_oe_o,
    output logic                soft_rst_o
);
    import brd_ctl_pkg::*;

    localparam logic [DEC_W-1:0] OFS_CHARN = OFS_CHAR0 + DEC_W'(8 * (NCHARS - 1));

    logic [DEC_W-1:0]       ofs;
    logic [ADDR_W-DEC_W-1:0] addr_hi_unused;
    logic [7:0]             brk_q;
    logic [DATA_W-1:0]      i2c_out_q;
    logic                   i2c_sel_q;
    logic                   wr_leds, wr_brk, wr_gpo, wr_oe, wr_out, wr_sel;
    logic                   wr_word, wr_char, key_hit;
    logic [IDX_W-1:0]       char_idx;
    logic [DATA_W-1:0]      rd_mux;

    assign ofs            = bus_addr[DEC_W-1:0];
    assign addr_hi_unused = bus_addr[ADDR_W-1:DEC_W];

    // write decode
    always_comb begin
        wr_leds  = bus_wr_en && (ofs == OFS_LEDS);
        wr_brk   = bus_wr_en && (ofs == OFS_BRK);
        wr_gpo   = bus_wr_en && (ofs == OFS_GPO);
        wr_oe    = bus_wr_en && (ofs == OFS_I2C_OE);
        wr_out   = bus_wr_en && (ofs == OFS_I2C_OUT);
        wr_sel   = bus_wr_en && (ofs == OFS_I2C_SEL);
        wr_word  = bus_wr_en && (ofs == OFS_HEXWORD);
        wr_char  = bus_wr_en && (ofs >= OFS_CHAR0) && (ofs <= OFS_CHARN)
                   && (ofs[2:0] == 3'b000);
        key_hit  = bus_wr_en && (ofs == OFS_SRST) && (bus_wdata == DATA_W'(SRST_KEY));
        char_idx = IDX_W'((ofs - OFS_CHAR0) >> 3);
    end

    // storage registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            led_o     <= 8'h00;
            brk_q     <= 8'h0A;
            gpo_o     <= 8'h00;
            i2c_oe_o  <= 2'b00;
            i2c_out_q <= DATA_W'(3);
            i2c_sel_q <= 1'b1;
        end else begin
            if (wr_leds) led_o     <= bus_wdata[7:0];
            if (wr_brk)  brk_q     <= bus_wdata[7:0];
            if (wr_gpo)  gpo_o     <= bus_wdata[7:0];
            if (wr_oe)   i2c_oe_o  <= bus_wdata[1:0];
            if (wr_out)  i2c_out_q <= bus_wdata;
            if (wr_sel)  i2c_sel_q <= bus_wdata[0];
        end
    end

    assign i2c_scl_o = i2c_out_q[1];
    assign i2c_sda_o = i2c_out_q[0];

    brd_disp_buf #(.NCHARS(NCHARS)) u_disp (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_word_i (wr_word),
        .wr_char_i (wr_char),
        .char_idx_i(char_idx),
        .word_i    (bus_wdata[4*NCHARS-1:0]),
        .char_i    (bus_wdata[7:0]),
        .disp_o    (disp_o)
    );

    brd_srst_fsm u_srst (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_hit_i(key_hit),
        .pulse_o  (soft_rst_o)
    );

    // read mux
    always_comb begin
        rd_mux = '0;
        case (ofs)
            OFS_STATUS:  rd_mux = BIG_ENDIAN ? DATA_W'(8'h12) : DATA_W'(8'h10);
            OFS_LEDS:    rd_mux = DATA_W'(led_o);
            OFS_BRK:     rd_mux = DATA_W'(brk_q);
            OFS_GPO:     rd_mux = DATA_W'(gpo_o);
            OFS_LOOP:    rd_mux = i2c_sel_q ? i2c_out_q : '0;
            OFS_I2C_IN:  rd_mux = DATA_W'({1'b1, i2c_sda_i});
            OFS_I2C_OE:  rd_mux = DATA_W'(i2c_oe_o);
            OFS_I2C_OUT: rd_mux = i2c_out_q;
            OFS_I2C_SEL: rd_mux = DATA_W'(i2c_sel_q);
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd_en;
            if (bus_rd_en) bus_rdata <= rd_mux;
        end
    end

    AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_en && (bus_addr[DEC_W-1:0] == OFS_LEDS)) |=> $stable(led_o)); // R3
    AST_GPO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_en && (bus_addr[DEC_W-1:0] == OFS_GPO)) |=> $stable(gpo_o)); // R7
    AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_en |=> bus_rvalid); // R11
    AST_SCL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_en && (bus_addr[DEC_W-1:0] == OFS_I2C_OUT)) |=> $stable(i2c_scl_o)); // R8

endmodule

// File: tb/brd_ctl_regs_tb.sv
`timescale 1ns/1ps
module brd_ctl_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        i2c_sda_i = 1'b1;
    logic [7:0]  led_o;
    logic [63:0] disp_o;
    logic [7:0]  gpo_o;
    logic        i2c_scl_o, i2c_sda_o;
    logic [1:0]  i2c_oe_o;
    logic        soft_rst_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    brd_ctl_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .i2c_sda_i(i2c_sda_i), .led_o(led_o),
        .disp_o(disp_o), .gpo_o(gpo_o), .i2c_scl_o(i2c_scl_o),
        .i2c_sda_o(i2c_sda_o), .i2c_oe_o(i2c_oe_o), .soft_rst_o(soft_rst_o)
    );

    // bench model
    logic [7:0]  m_led = 8'h00, m_gpo = 8'h00, m_brk = 8'h0A;
    logic [31:0] m_out = 32'h3;
    logic [63:0] m_disp = {8{8'h20}};

    function automatic logic [7:0] hexc(input logic [3:0] n);
        if (n < 10) return 8'd48 + 8'(n);
        return 8'd65 + 8'(n) - 8'd10;
    endfunction

    function automatic logic [63:0] hexword(input logic [31:0] w);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[8*i +: 8] = hexc(w[28-4*i +: 4]);
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [31:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a; bus_rd_en = 1'b1;
        @(negedge clk);
        bus_rd_en = 1'b0;
        check(req, {63'b0, bus_rvalid}, 64'd1);
        check(req, {32'b0, bus_rdata}, {32'b0, exp});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check("R10 disp", disp_o, {8{8'h20}});
        check("R10 led", {56'b0, led_o}, 64'h0);
        check("R10 srst", {63'b0, soft_rst_o}, 64'h0);
        rd_chk("R7 brk reset", 32'h00000508, 32'h0A);
        rd_chk("R7 gpo reset", 32'h00000A00, 32'h0);
        check("R8 scl/sda reset", {62'b0, i2c_scl_o, i2c_sda_o}, 64'h3);
        check("R8 oe reset", {62'b0, i2c_oe_o}, 64'h0);
        rd_chk("R8 sel reset", 32'h00000B18, 32'h1);
        rd_chk("R8 out reset", 32'h00000B10, 32'h3);
        rd_chk("R11 read timing", 32'h00000408, 32'h0);

        // R2 fixed values
        wr(32'h00000200, 32'hFFFFFFFF);
        wr(32'h00000210, 32'hFFFFFFFF);
        rd_chk("R2 switch", 32'h00000200, 32'h0);
        rd_chk("R2 jumper", 32'h00000210, 32'h0);
        rd_chk("R2 status", 32'h00000208, 32'h10);

        // R1 aliasing and unmapped
        wr(32'hABC00408, 32'h123456A5);
        m_led = 8'hA5;
        check("R1 alias write led", {56'b0, led_o}, {56'b0, m_led});
        rd_chk("R1 alias read led", 32'h7FF00408, {24'b0, m_led});
        wr(32'h00000300, 32'hDEADBEEF);
        rd_chk("R1 unmapped read", 32'h00000300, 32'h0);
        check("R1 unmapped no effect led", {56'b0, led_o}, {56'b0, m_led});
        check("R1 unmapped no effect disp", disp_o, m_disp);
        rd_chk("R1 hexword reads zero", 32'h00000410, 32'h0);

        // R4 hex word, R5 per character
        wr(32'h00000410, 32'h09AF3C5E);
        m_disp = hexword(32'h09AF3C5E);
        check("R4 hexword", disp_o, m_disp);
        check("R4 char0 is MS nibble", {56'b0, disp_o[7:0]}, 64'h30);
        wr(32'h00000450, 32'h0000005A);
        m_disp[63:56] = 8'h5A;
        check("R5 char7", disp_o, m_disp);
        wr(32'h00000418, 32'h00000021);
        m_disp[7:0] = 8'h21;
        check("R5 char0", disp_o, m_disp);
        wr(32'h0000041C, 32'h00000077);
        check("R5 misaligned ignored", disp_o, m_disp);

        // R6 soft reset
        wr(32'h00000500, 32'h00000041);
        check("R6 wrong key", {63'b0, soft_rst_o}, 64'h0);
        wr(32'h00000500, 32'h00000142);
        check("R6 wide wrong key", {63'b0, soft_rst_o}, 64'h0);
        wr(32'h00000500, 32'h00000042);
        check("R6 pulse high", {63'b0, soft_rst_o}, 64'h1);
        @(negedge clk);
        check("R6 pulse one cycle", {63'b0, soft_rst_o}, 64'h0);

        // R8 / R9 I2C
        wr(32'h00000B08, 32'hFFFFFFFE);
        check("R8 oe two bits", {62'b0, i2c_oe_o}, 64'h2);
        wr(32'h00000B10, 32'hC0DE0002);
        m_out = 32'hC0DE0002;
        check("R8 scl/sda", {62'b0, i2c_scl_o, i2c_sda_o}, 64'h2);
        rd_chk("R9 loop sel1", 32'h00000A08, m_out);
        i2c_sda_i = 1'b0;
        rd_chk("R9 in sda0", 32'h00000B00, 32'h2);
        i2c_sda_i = 1'b1;
        rd_chk("R9 in sda1", 32'h00000B00, 32'h3);
        wr(32'h00000B18, 32'h00000000);
        rd_chk("R9 loop sel0", 32'h00000A08, 32'h0);
        rd_chk("R8 sel stored", 32'h00000B18, 32'h0);

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [31:0] a_hi, d;
            int k;
            a_hi = {$urandom_range(0, 4095), 20'h0};
            d = $urandom;
            k = $urandom_range(0, 5);
            case (k)
                0: begin wr(a_hi | 32'h408, d); m_led = d[7:0];
                         check("R3 rnd led", {56'b0, led_o}, {56'b0, m_led}); end
                1: begin wr(a_hi | 32'hA00, d); m_gpo = d[7:0];
                         check("R7 rnd gpo", {56'b0, gpo_o}, {56'b0, m_gpo}); end
                2: begin wr(a_hi | 32'h508, d); m_brk = d[7:0];
                         rd_chk("R7 rnd brk", 32'h508, {24'b0, m_brk}); end
                3: begin wr(a_hi | 32'h410, d); m_disp = hexword(d);
                         check("R4 rnd hexword", disp_o, m_disp); end
                4: begin
                       int i;
                       i = $urandom_range(0, 7);
                       wr(a_hi | (32'h418 + 32'(8 * i)), d);
                       m_disp[8*i +: 8] = d[7:0];
                       check("R5 rnd char", disp_o, m_disp);
                   end
                default: begin wr(a_hi | 32'hB10, d); m_out = d;
                         check("R8 rnd i2c", {62'b0, i2c_scl_o, i2c_sda_o}, {62'b0, m_out[1:0]});
                         rd_chk("R8 rnd out read", 32'hB10, m_out); end
            endcase
        end
        check("R3 final led", {56'b0, led_o}, {56'b0, m_led});
        check("R6 idle after random", {63'b0, soft_rst_o}, 64'h0);

        finish_run();
    end

endmodule